// File: doc/BRIEF.md
# Reserved Load and Conditional Store Unit

This block carries out the reserved-load and conditional-store pair for a 64-bit core. A reserved load takes the base register value as its address, with no offset. It asks the translation unit for a read, fetches 4 or 8 bytes from memory and returns the value to the destination register. A word load is sign-extended to the register width. When the whole sequence completes without a fault, the unit records a single reservation, made of the virtual address and a valid bit.

A conditional store settles its outcome at once. It succeeds only if the reservation is valid and its address equals the store's base address. The unit writes the status to the destination register and clears the reservation in every case. Only a successful store goes on to translate its address as a write, announce the effective address to memory and then send the data. Acquire and release flags travel with every memory request as sideband bits and are not enforced. Every memory request is tagged as reserved/conditional.

The controller is a six-state machine with these states:
- `ST_IDLE` waits for a request.
- `ST_LR_XLATE` and `ST_LR_READ` translate and read for a load.
- `ST_SC_XLATE`, `ST_SC_ANNOUNCE` and `ST_SC_WRITE` translate, announce and write for a store.

The transitions are:
- A request starts in `ST_IDLE`.
- A load moves to `ST_LR_XLATE`.
- A successful store moves to `ST_SC_XLATE`.
- A failed store or an illegal width stays in `ST_IDLE`.
- Each later state moves on when its responder reports done without a fault.
- Any fault, and the end of the last phase, returns the machine to `ST_IDLE`.

Top module: `lrsc_unit`

## Requirements
- R1: The access address is `req_base` unchanged. A load asks for translation with `xl_write` low and `xl_vaddr` equal to `req_base`, and then reads from the returned `xl_paddr`.
- R2: `req_size` encodes the width: 2'b10 selects a word and 2'b11 a doubleword. Any other code pulses `int_err` for one cycle, the cycle after the request. Such a request produces no translation, no memory request and no register write.
- R3: A conditional store pulses `rd_we` in the cycle after it is accepted, no later than its first translation request. `rd_data` carries 0 on success and 1 on failure, zero-extended to 64 bits.
- R4: A failed conditional store makes no translation request, no announce and no memory write.
- R5: A successful store translates with `xl_write` high, then issues an announce (`mem_op` 1) and then a write (`mem_op` 2) to `xl_paddr`. A fault in any phase pulses `exc_valid` and skips the later phases. `exc_addr` is the virtual address for a translation fault and the physical address for a memory fault.
- R6: A word store places the low 32 bits of `req_src` in `mem_wdata` and zeroes the upper half. A doubleword store sends all 64 bits.
- R7: Every memory request carries the request's `req_aq` and `req_rl` on `mem_aq` and `mem_rl`, has `mem_resv` high, and has `mem_size` high for a doubleword.
- R8: A store succeeds only when a reservation is valid and its address equals `req_base`. Every conditional store, successful or not, clears the reservation, and no reservation exists after reset.
- R9: A load whose read completes without a fault pulses `rd_we`. `rd_data` is then the read data, sign-extended from bit 31 for a word. Such a load also sets the reservation to its address. A load that faults in translation or in the read sets no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while `busy` is low |
| req_sc | input | 1 | 1 = conditional store, 0 = reserved load |
| req_size | input | 2 | Width code (2'b10 word, 2'b11 doubleword) |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| req_base | input | 64 | Base register value (the address) |
| req_src | input | 64 | Source register value for stores |
| busy | output | 1 | Sequence in progress |
| xl_valid | output | 1 | Translation request |
| xl_vaddr | output | 64 | Virtual address to translate |
| xl_write | output | 1 | 1 = write access, 0 = read access |
| xl_done | input | 1 | Translation response |
| xl_fault | input | 1 | Translation failed |
| xl_paddr | input | 64 | Translated address |
| mem_valid | output | 1 | Memory request |
| mem_op | output | 2 | 0 read, 1 announce, 2 write |
| mem_addr | output | 64 | Physical address |
| mem_size | output | 1 | 1 = doubleword |
| mem_wdata | output | 64 | Store data |
| mem_aq | output | 1 | Acquire sideband |
| mem_rl | output | 1 | Release sideband |
| mem_resv | output | 1 | Reserved/conditional tag |
| mem_done | input | 1 | Memory response |
| mem_fault | input | 1 | Memory access failed |
| mem_rdata | input | 64 | Read data |
| rd_we | output | 1 | Destination register write pulse |
| rd_data | output | 64 | Destination value |
| exc_valid | output | 1 | Exception pulse |
| exc_addr | output | 64 | Faulting address |
| int_err | output | 1 | Illegal width pulse |

## Verification
Stores are issued to the reserved address, to a different address, twice in a row, right after reset and after loads that faulted. Together these separate a correct address-matched, self-clearing reservation from one that ignores the address, is never cleared, or is set by a faulted load. Faults are injected one at a time into translation, read, announce and write. This shows that each fault stops exactly the later phases and reports the correct virtual or physical address. Word loads with bit 31 set and word stores with a nonzero upper source half distinguish sign extension and truncation from passing the value through. Illegal width codes are mixed into a seeded random stream over a small address pool so that reservation matches happen often.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LR_XLATE,
        ST_LR_READ,
        ST_SC_XLATE,
        ST_SC_ANNOUNCE,
        ST_SC_WRITE
    } lrsc_state_t;

    localparam logic [1:0] MOP_READ     = 2'd0;
    localparam logic [1:0] MOP_ANNOUNCE = 2'd1;
    localparam logic [1:0] MOP_WRITE    = 2'd2;

    localparam logic [1:0] SZ_WORD  = 2'b10;
    localparam logic [1:0] SZ_DWORD = 2'b11;
endpackage

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic [AW-1:0] set_addr_i,
    input  logic          clr_i,
    input  logic [AW-1:0] cmp_addr_i,
    output logic          hit_o
);
    logic          valid_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
        end else if (clr_i) begin
            valid_q <= 1'b0;
        end else if (set_i) begin
            valid_q <= 1'b1;
            addr_q  <= set_addr_i;
        end
    end

    assign hit_o = valid_q && (addr_q == cmp_addr_i);
endmodule

// File: rtl/lrsc_fmt.sv
module lrsc_fmt #(
    parameter int XLEN = 64
) (
    input  logic            dword_i,
    input  logic [XLEN-1:0] load_raw_i,
    input  logic [XLEN-1:0] store_raw_i,
    output logic [XLEN-1:0] load_o,
    output logic [XLEN-1:0] store_o
);
    localparam int HALF = XLEN / 2;

    always_comb begin
        if (dword_i) begin
            load_o  = load_raw_i;
            store_o = store_raw_i;
        end else begin
            load_o  = {{HALF{load_raw_i[HALF-1]}}, load_raw_i[HALF-1:0]};
            store_o = {{HALF{1'b0}}, store_raw_i[HALF-1:0]};
        end
    end
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
    import lrsc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_sc,
    input  logic [1:0]      req_size,
    input  logic            req_aq,
    input  logic            req_rl,
    input  logic [XLEN-1:0] req_base,
    input  logic [XLEN-1:0] req_src,
    output logic            busy,
    output logic            xl_valid,
    output logic [XLEN-1:0] xl_vaddr,
    output logic            xl_write,
    input  logic            xl_done,
    input  logic            xl_fault,
    input  logic [XLEN-1:0] xl_paddr,
    output logic            mem_valid,
    output logic [1:0]      mem_op,
    output logic [XLEN-1:0] mem_addr,
    output logic            mem_size,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_aq,
    output logic            mem_rl,
    output logic            mem_resv,
    input  logic            mem_done,
    input  logic            mem_fault,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            rd_we,
    output logic [XLEN-1:0] rd_data,
    output logic            exc_valid,
    output logic [XLEN-1:0] exc_addr,
    output logic            int_err
);
    lrsc_state_t     state_q, state_d;
    logic [XLEN-1:0] vaddr_q, paddr_q, src_q;
    logic            dword_q, aq_q, rl_q;
    logic            size_ok, accept, resv_hit, resv_set, resv_clr;
    logic [XLEN-1:0] load_val;

    assign size_ok  = (req_size == SZ_WORD) || (req_size == SZ_DWORD);
    assign accept   = (state_q == ST_IDLE) && req_valid && size_ok;
    assign resv_clr = accept && req_sc;
    assign resv_set = (state_q == ST_LR_READ) && mem_done && !mem_fault;

    lrsc_resv #(.AW(XLEN)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (resv_set),
        .set_addr_i (vaddr_q),
        .clr_i      (resv_clr),
        .cmp_addr_i (req_base),
        .hit_o      (resv_hit)
    );

    lrsc_fmt #(.XLEN(XLEN)) u_fmt (
        .dword_i     (dword_q),
        .load_raw_i  (mem_rdata),
        .store_raw_i (src_q),
        .load_o      (load_val),
        .store_o     (mem_wdata)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = req_sc ? (resv_hit ? ST_SC_XLATE : ST_IDLE) : ST_LR_XLATE;
            end
            ST_LR_XLATE:    if (xl_done)  state_d = xl_fault  ? ST_IDLE : ST_LR_READ;
            ST_LR_READ:     if (mem_done) state_d = ST_IDLE;
            ST_SC_XLATE:    if (xl_done)  state_d = xl_fault  ? ST_IDLE : ST_SC_ANNOUNCE;
            ST_SC_ANNOUNCE: if (mem_done) state_d = mem_fault ? ST_IDLE : ST_SC_WRITE;
            ST_SC_WRITE:    if (mem_done) state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // State register and request context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vaddr_q <= '0;
            paddr_q <= '0;
            src_q   <= '0;
            dword_q <= 1'b0;
            aq_q    <= 1'b0;
            rl_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                vaddr_q <= req_base;
                src_q   <= req_src;
                dword_q <= req_size[0];
                aq_q    <= req_aq;
                rl_q    <= req_rl;
            end
            if (xl_valid && xl_done) paddr_q <= xl_paddr;
        end
    end

    // Result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_we     <= 1'b0;
            rd_data   <= '0;
            exc_valid <= 1'b0;
            exc_addr  <= '0;
            int_err   <= 1'b0;
        end else begin
            rd_we     <= 1'b0;
            exc_valid <= 1'b0;
            int_err   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid && !size_ok) begin
                        int_err <= 1'b1;
                    end else if (accept && req_sc) begin
                        rd_we   <= 1'b1;
                        rd_data <= {{(XLEN-1){1'b0}}, !resv_hit};
                    end
                end
                ST_LR_XLATE, ST_SC_XLATE: begin
                    if (xl_done && xl_fault) begin
                        exc_valid <= 1'b1;
                        exc_addr  <= vaddr_q;
                    end
                end
                ST_LR_READ: begin
                    if (mem_done && mem_fault) begin
                        exc_valid <= 1'b1;
                        exc_addr  <= paddr_q;
                    end else if (mem_done) begin
                        rd_we   <= 1'b1;
                        rd_data <= load_val;
                    end
                end
                ST_SC_ANNOUNCE, ST_SC_WRITE: begin
                    if (mem_done && mem_fault) begin
                        exc_valid <= 1'b1;
                        exc_addr  <= paddr_q;
                    end
                end
                default: ;
            endcase
        end
    end

    // Request outputs decoded from the state
    always_comb begin
        xl_valid  = (state_q == ST_LR_XLATE) || (state_q == ST_SC_XLATE);
        xl_write  = (state_q == ST_SC_XLATE);
        mem_valid = (state_q == ST_LR_READ) || (state_q == ST_SC_ANNOUNCE) ||
                    (state_q == ST_SC_WRITE);
        mem_op    = (state_q == ST_SC_ANNOUNCE) ? MOP_ANNOUNCE :
                    (state_q == ST_SC_WRITE)    ? MOP_WRITE : MOP_READ;
    end

    assign busy     = (state_q != ST_IDLE);
    assign xl_vaddr = vaddr_q;
    assign mem_addr = paddr_q;
    assign mem_size = dword_q;
    assign mem_aq   = aq_q;
    assign mem_rl   = rl_q;
    assign mem_resv = mem_valid;
endmodule

// File: rtl/lrsc_chk.sv
module lrsc_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic [XLEN-1:0] req_base,
    input logic            busy,
    input logic            xl_valid,
    input logic [XLEN-1:0] xl_vaddr,
    input logic            xl_write,
    input logic            mem_valid,
    input logic [1:0]      mem_op,
    input logic            mem_size,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_done,
    input logic            mem_fault,
    input logic            rd_we,
    input logic [XLEN-1:0] rd_data,
    input logic            exc_valid,
    input logic            int_err
);
    localparam int HALF = XLEN / 2;

    a_r1_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xl_valid) && !xl_write |-> xl_vaddr == $past(req_base));

    a_r2_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        int_err |-> !rd_we && !exc_valid && !busy);

    a_r3_status_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xl_valid) && xl_write |-> rd_we && rd_data == '0);

    a_r4_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rd_we && rd_data == {{(XLEN-1){1'b0}}, 1'b1} |-> !xl_valid && !mem_valid);

    a_r5_announce_first: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_op == 2'd2 && !$past(mem_valid && mem_op == 2'd2)
        |-> $past(mem_valid && mem_op == 2'd1 && mem_done && !mem_fault));

    a_r6_word_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_op == 2'd2 && !mem_size |-> mem_wdata[XLEN-1:HALF] == '0);

    a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_we, exc_valid, int_err}));
endmodule

bind lrsc_unit lrsc_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_base  (req_base),
    .busy      (busy),
    .xl_valid  (xl_valid),
    .xl_vaddr  (xl_vaddr),
    .xl_write  (xl_write),
    .mem_valid (mem_valid),
    .mem_op    (mem_op),
    .mem_size  (mem_size),
    .mem_wdata (mem_wdata),
    .mem_done  (mem_done),
    .mem_fault (mem_fault),
    .rd_we     (rd_we),
    .rd_data   (rd_data),
    .exc_valid (exc_valid),
    .int_err   (int_err)
);

// File: tb/sim_lrsc_unit.sv
`timescale 1ns/1ps
module sim_lrsc_unit;
    localparam logic [63:0] PMASK = 64'h0000_8000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_sc = 1'b0, req_aq = 1'b0, req_rl = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [63:0] req_base = '0, req_src = '0;
    logic        busy, xl_valid, xl_write, xl_done, xl_fault;
    logic [63:0] xl_vaddr, xl_paddr;
    logic        mem_valid, mem_size, mem_aq, mem_rl, mem_resv, mem_done, mem_fault;
    logic [1:0]  mem_op;
    logic [63:0] mem_addr, mem_wdata, mem_rdata, rd_data, exc_addr;
    logic        rd_we, exc_valid, int_err;
    logic        f_xl = 1'b0, f_rd = 1'b0, f_an = 1'b0, f_wr = 1'b0;

    int checks = 0, errors = 0;
    int cyc = 0;
    int n_rdwe, n_exc, n_int, n_xl, n_mr, n_an, n_wr;
    int c_rd, c_xl, c_an, c_wr;
    logic [63:0] l_rd, l_exc, l_xv, l_ma, l_wd;
    logic l_xw, l_aq, l_rl, l_rs, l_sz;
    logic        ref_valid = 1'b0;
    logic [63:0] ref_addr = '0;

    always #2.5 clk = ~clk;

    function automatic logic [63:0] rdfn(input logic [63:0] a);
        return {a[31:0] ^ 32'hC3A5_9E17, a[63:32] ^ a[31:0] ^ 32'h8000_0001};
    endfunction

    function automatic logic [63:0] ldext(input logic [63:0] v, input logic dw);
        return dw ? v : {{32{v[31]}}, v[31:0]};
    endfunction

    assign xl_done   = xl_valid;
    assign xl_fault  = xl_valid & f_xl;
    assign xl_paddr  = xl_vaddr ^ PMASK;
    assign mem_done  = mem_valid;
    assign mem_fault = mem_valid & ((mem_op == 2'd0) ? f_rd : (mem_op == 2'd1) ? f_an : f_wr);
    assign mem_rdata = rdfn(mem_addr);

    lrsc_unit u0 (.*);

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rd_we)     begin n_rdwe++; l_rd = rd_data; c_rd = cyc; end
        if (exc_valid) begin n_exc++; l_exc = exc_addr; end
        if (int_err)   n_int++;
        if (xl_valid)  begin n_xl++; l_xw = xl_write; l_xv = xl_vaddr; c_xl = cyc; end
        if (mem_valid) begin
            l_ma = mem_addr; l_aq = mem_aq; l_rl = mem_rl; l_rs = mem_resv; l_sz = mem_size;
            case (mem_op)
                2'd0: n_mr++;
                2'd1: begin n_an++; c_an = cyc; end
                default: begin n_wr++; c_wr = cyc; l_wd = mem_wdata; end
            endcase
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic op(input logic sc, input logic [1:0] sz, input logic [63:0] base,
                      input logic [63:0] src, input logic aq, input logic rl,
                      input logic fx, input logic fr, input logic fa, input logic fw);
        logic legal, dw, succ;
        logic [63:0] pa;
        legal = (sz == 2'b10) || (sz == 2'b11);
        dw = sz[0];
        pa = base ^ PMASK;
        n_rdwe = 0; n_exc = 0; n_int = 0; n_xl = 0; n_mr = 0; n_an = 0; n_wr = 0;
        c_rd = 0; c_xl = 0; c_an = 0; c_wr = 0;
        f_xl = fx; f_rd = fr; f_an = fa; f_wr = fw;
        req_valid = 1'b1; req_sc = sc; req_size = sz; req_base = base;
        req_src = src; req_aq = aq; req_rl = rl;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (7) @(negedge clk);
        if (!legal) begin
            chk(n_int == 1 && n_rdwe == 0 && n_xl == 0 && n_mr + n_an + n_wr == 0,
                "R2 illegal width", 64'(n_int), 64'd1);
        end else if (!sc) begin
            chk(n_xl == 1 && l_xv == base && !l_xw, "R1 load address", l_xv, base);
            if (fx) begin
                chk(n_exc == 1 && l_exc == base && n_mr == 0 && n_rdwe == 0,
                    "R9 load xlate fault", l_exc, base);
            end else begin
                chk(n_mr == 1 && l_ma == pa, "R1 load paddr", l_ma, pa);
                chk(l_aq == aq && l_rl == rl && l_rs && l_sz == dw, "R7 load sideband",
                    64'({l_aq, l_rl, l_rs, l_sz}), 64'({aq, rl, 1'b1, dw}));
                if (fr) begin
                    chk(n_exc == 1 && l_exc == pa && n_rdwe == 0, "R9 load read fault", l_exc, pa);
                end else begin
                    chk(n_rdwe == 1 && n_exc == 0 && l_rd == ldext(rdfn(pa), dw),
                        "R9 load data", l_rd, ldext(rdfn(pa), dw));
                    ref_valid = 1'b1;
                    ref_addr  = base;
                end
            end
        end else begin
            succ = ref_valid && ref_addr == base;
            ref_valid = 1'b0;
            chk(n_rdwe == 1 && l_rd == {63'd0, !succ}, "R3 R8 status", l_rd, {63'd0, !succ});
            if (!succ) begin
                chk(n_xl == 0 && n_an == 0 && n_wr == 0 && n_exc == 0, "R4 failed store quiet",
                    64'(n_xl + n_an + n_wr), 64'd0);
            end else begin
                chk(n_xl == 1 && l_xw && l_xv == base && c_rd <= c_xl, "R5 R3 write xlate",
                    l_xv, base);
                if (fx) begin
                    chk(n_exc == 1 && l_exc == base && n_an == 0 && n_wr == 0,
                        "R5 xlate fault", l_exc, base);
                end else begin
                    chk(n_an == 1 && l_ma == pa && l_aq == aq && l_rl == rl && l_rs,
                        "R5 R7 announce", l_ma, pa);
                    if (fa) begin
                        chk(n_exc == 1 && l_exc == pa && n_wr == 0, "R5 announce fault", l_exc, pa);
                    end else begin
                        chk(n_wr == 1 && c_an < c_wr && l_sz == dw, "R5 write after announce",
                            64'(n_wr), 64'd1);
                        chk(l_wd == (dw ? src : {32'd0, src[31:0]}), "R6 store data", l_wd,
                            dw ? src : {32'd0, src[31:0]});
                        chk(n_exc == (fw ? 1 : 0) && (!fw || l_exc == pa), "R5 write fault",
                            64'(n_exc), fw ? 64'd1 : 64'd0);
                    end
                end
            end
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] pool [4];
        void'($urandom(32'd715));
        pool[0] = 64'h0000_0000_8000_1000; pool[1] = 64'h0000_0001_0000_2008;
        pool[2] = 64'hFFFF_FFFF_FFF0_0040; pool[3] = 64'h0000_0000_0000_3010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !rd_we && !exc_valid && !int_err && !xl_valid && !mem_valid,
            "R8 reset state", 64'({busy, rd_we, exc_valid, int_err, xl_valid, mem_valid}), 64'd0);
        // R8: no reservation after reset
        op(1, 2'b11, pool[0], 64'h1234, 0, 0, 0, 0, 0, 0);
        // R9: word load sign-extended, then matching store succeeds
        op(0, 2'b10, pool[0], 0, 1, 0, 0, 0, 0, 0);
        op(1, 2'b10, pool[0], 64'hDEAD_BEEF_CAFE_F00D, 0, 1, 0, 0, 0, 0);
        // R8: second store fails, reservation cleared
        op(1, 2'b10, pool[0], 64'h5, 0, 0, 0, 0, 0, 0);
        // R8: address mismatch fails and clears
        op(0, 2'b11, pool[1], 0, 0, 0, 0, 0, 0, 0);
        op(1, 2'b11, pool[2], 64'h7, 0, 0, 0, 0, 0, 0);
        op(1, 2'b11, pool[1], 64'h7, 0, 0, 0, 0, 0, 0);
        // R9: faulted loads set nothing
        op(0, 2'b11, pool[3], 0, 0, 0, 1, 0, 0, 0);
        op(1, 2'b11, pool[3], 64'h9, 0, 0, 0, 0, 0, 0);
        op(0, 2'b10, pool[3], 0, 0, 0, 0, 1, 0, 0);
        op(1, 2'b10, pool[3], 64'h9, 0, 0, 0, 0, 0, 0);
        // R5: faults on each store phase
        op(0, 2'b11, pool[2], 0, 0, 0, 0, 0, 0, 0);
        op(1, 2'b11, pool[2], 64'hA, 1, 1, 1, 0, 0, 0);
        op(0, 2'b11, pool[2], 0, 0, 0, 0, 0, 0, 0);
        op(1, 2'b11, pool[2], 64'hA, 0, 0, 0, 0, 1, 0);
        op(0, 2'b11, pool[2], 0, 0, 0, 0, 0, 0, 0);
        op(1, 2'b11, pool[2], 64'hA, 0, 0, 0, 0, 0, 1);
        // R2: illegal widths
        op(0, 2'b00, pool[1], 0, 0, 0, 0, 0, 0, 0);
        op(1, 2'b01, pool[1], 0, 0, 0, 0, 0, 0, 0);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] r;
            logic [1:0] sz;
            r  = 3'($urandom);
            sz = (r == 0) ? 2'($urandom % 2) : (r[0] ? 2'b11 : 2'b10);
            op(1'($urandom), sz, pool[$urandom % 4], {$urandom, $urandom},
               1'($urandom), 1'($urandom),
               ($urandom % 10) == 0, ($urandom % 10) == 0,
               ($urandom % 10) == 0, ($urandom % 10) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule